// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregator with Power-Up Hold-Off

The block collects interrupt requests into one top-level pending register and drives a single interrupt line. Two secondary groups, one for a USB core and one for a DMA engine, each keep their own pending and mask registers. Each group folds into summary bits of the top-level register: the USB group has one summary for its lower half-word (transmit) and one for its upper half-word (receive), and the DMA group has one summary for the whole word. Software reaches every register through a 32-bit word-access bus. Each register set has separate set, clear and mask addresses, so one bus write never needs a read-modify-write.

The output line's polarity is programmable. A hold-off timer forces the line inactive for a fixed number of cycles after the power input turns on. The request channel uses valid/ready, but ready is tied high, so there is no back-pressure: a request is accepted on every cycle in which `bus_valid` is high. The read response and the USB clear strobe are one-cycle valid pulses with no ready. The receiver must take them in the cycle they appear.

Register byte offsets: top source/set/clear/mask at 0x00/0x04/0x08/0x0C, USB group at 0x10/0x14/0x18/0x1C, DMA group at 0x20/0x24/0x28/0x2C, and configuration at 0x30. Every other offset is unmapped.

Top module: `irq_aggregator`

## Requirements
- R1: A write to a set offset ORs the written data into that pending register. A write to a clear offset ANDs the register with the inverse of the data. A read of the source, set or clear offset returns the pending value.
- R2: After reset the top-level mask reads 0xFFFFFFFF. All pending registers, group masks and the configuration read zero, and `irq` is low.
- R3: Whenever the USB group is written (set, clear or mask), top-level bit 9 becomes the OR of the unmasked pending USB bits [15:0], and top-level bit 8 becomes the OR of the unmasked pending USB bits [31:16].
- R4: Whenever the DMA group is written, top-level bit 24 becomes the OR of the unmasked pending DMA bits.
- R5: Configuration bit 17 selects polarity. When it is 1, `irq` is high while any unmasked top-level bit is pending. When it is 0, `irq` is high while none is pending.
- R6: In both polarities `irq` is gated by an enable flag. The flag clears when power turns on and sets HOLD_CYCLES cycles later, but only if power is still on at that point.
- R7: A high `pwr_on` restarts the hold-off only if power was recorded off. Power turning off only records the off state and leaves the enable flag unchanged.
- R8: When `evt_valid` is high, top-level bit `evt_num` takes the value of `evt_level`. A summary update in the same cycle takes priority over the event.
- R9: A write to the USB clear offset produces a one-cycle `usb_clr_valid` in the following cycle, with `usb_clr_data` equal to the inverted write data.
- R10: Reads of unmapped offsets return zero, and writes to unmapped offsets change no register.
- R11: `bus_ready` is always high. A read produces `rsp_valid` with data in the cycle after it is accepted. `irq` is registered and follows register changes one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Request ready, always high |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | DATA_W | Read response data |
| evt_valid | input | 1 | Core event valid |
| evt_num | input | EVT_W | Top-level bit index of the event |
| evt_level | input | 1 | Level to store in that bit |
| pwr_on | input | 1 | Power state, high = on |
| irq | output | 1 | Interrupt line |
| usb_clr_valid | output | 1 | USB clear strobe |
| usb_clr_data | output | DATA_W | Inverted USB clear value |

## Verification
The assertions check on every cycle that the USB and DMA summary bits match their groups one cycle after any group write. They also check that a cleared enable keeps `irq` low, that a power rise clears the enable, that the clear strobe and read response follow their requests with the right timing and data, and that unmapped writes leave the configuration untouched. The bench's scenarios are needed for the rest: the full hold-off length, a power drop during the countdown leaving the line gated, both polarities, and event ordering. These come from a behavioural model that is compared with the outputs on every clock.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_TOP_SRC, SEL_TOP_SET, SEL_TOP_CLR, SEL_TOP_MASK,
    SEL_USB_SRC, SEL_USB_SET, SEL_USB_CLR, SEL_USB_MASK,
    SEL_DMA_SRC, SEL_DMA_SET, SEL_DMA_CLR, SEL_DMA_MASK,
    SEL_CFG
  } reg_sel_e;

  localparam logic [7:0] OFS_TOP_SRC  = 8'h00;
  localparam logic [7:0] OFS_TOP_SET  = 8'h04;
  localparam logic [7:0] OFS_TOP_CLR  = 8'h08;
  localparam logic [7:0] OFS_TOP_MASK = 8'h0C;
  localparam logic [7:0] OFS_USB_SRC  = 8'h10;
  localparam logic [7:0] OFS_USB_SET  = 8'h14;
  localparam logic [7:0] OFS_USB_CLR  = 8'h18;
  localparam logic [7:0] OFS_USB_MASK = 8'h1C;
  localparam logic [7:0] OFS_DMA_SRC  = 8'h20;
  localparam logic [7:0] OFS_DMA_SET  = 8'h24;
  localparam logic [7:0] OFS_DMA_CLR  = 8'h28;
  localparam logic [7:0] OFS_DMA_MASK = 8'h2C;
  localparam logic [7:0] OFS_CFG      = 8'h30;

  localparam int unsigned POL_BIT     = 17;
  localparam int unsigned USB_TX_BIT  = 9;
  localparam int unsigned USB_RX_BIT  = 8;
  localparam int unsigned DMA_SUM_BIT = 24;

  function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
    reg_sel_e s;
    case (ofs)
      OFS_TOP_SRC:  s = SEL_TOP_SRC;
      OFS_TOP_SET:  s = SEL_TOP_SET;
      OFS_TOP_CLR:  s = SEL_TOP_CLR;
      OFS_TOP_MASK: s = SEL_TOP_MASK;
      OFS_USB_SRC:  s = SEL_USB_SRC;
      OFS_USB_SET:  s = SEL_USB_SET;
      OFS_USB_CLR:  s = SEL_USB_CLR;
      OFS_USB_MASK: s = SEL_USB_MASK;
      OFS_DMA_SRC:  s = SEL_DMA_SRC;
      OFS_DMA_SET:  s = SEL_DMA_SET;
      OFS_DMA_CLR:  s = SEL_DMA_CLR;
      OFS_DMA_MASK: s = SEL_DMA_MASK;
      OFS_CFG:      s = SEL_CFG;
      default:      s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/irq_group.sv
module irq_group #(
  parameter int unsigned W        = 32,
  parameter int unsigned NSUM     = 1,
  parameter logic [W-1:0] MASK_RST = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_we,
  input  logic            clr_we,
  input  logic            mask_we,
  input  logic [W-1:0]    wdata,
  output logic [W-1:0]    pend_q,
  output logic [W-1:0]    mask_q,
  output logic            upd,
  output logic [NSUM-1:0] sum_d
);
  localparam int unsigned SW = W / NSUM;

  logic [W-1:0] pend_d, mask_d;

  always_comb begin
    pend_d = pend_q;
    if (set_we) pend_d = pend_d | wdata;
    if (clr_we) pend_d = pend_d & ~wdata;
    mask_d = mask_we ? wdata : mask_q;
  end

  assign upd = set_we | clr_we | mask_we;

  for (genvar g = 0; g < NSUM; g++) begin : g_sum
    assign sum_d[g] = |(pend_d[g*SW +: SW] & ~mask_d[g*SW +: SW]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= MASK_RST;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/irq_holdoff.sv
module irq_holdoff #(
  parameter int unsigned HOLD_CYCLES = 30_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_on,
  output logic en
);
  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);

  logic          pwr_q, run_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q <= 1'b0;
      run_q <= 1'b0;
      en    <= 1'b0;
      cnt_q <= '0;
    end else begin
      pwr_q <= pwr_on;
      if (pwr_on && !pwr_q) begin
        en    <= 1'b0;
        run_q <= 1'b1;
        cnt_q <= CW'(HOLD_CYCLES);
      end else if (run_q) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          en    <= pwr_on;
        end
      end
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned EVT_W       = 5,
  parameter int unsigned HOLD_CYCLES = 30_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              evt_valid,
  input  logic [EVT_W-1:0]  evt_num,
  input  logic              evt_level,
  input  logic              pwr_on,
  output logic              irq,
  output logic              usb_clr_valid,
  output logic [DATA_W-1:0] usb_clr_data
);
  localparam int unsigned USB_NSUM = 2;
  localparam int unsigned DMA_NSUM = 1;

  reg_sel_e sel;
  logic     wr, rd, bad_addr;

  always_comb begin
    if ((ADDR_W > 8) && ((bus_addr >> 8) != '0)) sel = SEL_NONE;
    else sel = decode_ofs(bus_addr[7:0]);
  end

  assign bus_ready = 1'b1;
  assign wr        = bus_valid & bus_write;
  assign rd        = bus_valid & ~bus_write;
  assign bad_addr  = (sel == SEL_NONE);

  logic [DATA_W-1:0]   usb_pend_q, usb_mask_q, dma_pend_q, dma_mask_q;
  logic                usb_upd, dma_upd;
  logic [USB_NSUM-1:0] usb_sum;
  logic [DMA_NSUM-1:0] dma_sum;

  irq_group #(.W(DATA_W), .NSUM(USB_NSUM), .MASK_RST('0)) u_usb (
    .clk(clk), .rst_n(rst_n),
    .set_we(wr && sel == SEL_USB_SET),
    .clr_we(wr && sel == SEL_USB_CLR),
    .mask_we(wr && sel == SEL_USB_MASK),
    .wdata(bus_wdata),
    .pend_q(usb_pend_q), .mask_q(usb_mask_q),
    .upd(usb_upd), .sum_d(usb_sum)
  );

  irq_group #(.W(DATA_W), .NSUM(DMA_NSUM), .MASK_RST('0)) u_dma (
    .clk(clk), .rst_n(rst_n),
    .set_we(wr && sel == SEL_DMA_SET),
    .clr_we(wr && sel == SEL_DMA_CLR),
    .mask_we(wr && sel == SEL_DMA_MASK),
    .wdata(bus_wdata),
    .pend_q(dma_pend_q), .mask_q(dma_mask_q),
    .upd(dma_upd), .sum_d(dma_sum)
  );

  logic hold_en;

  irq_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .en(hold_en)
  );

  logic [DATA_W-1:0] top_q, top_d, tmask_q, cfg_q;

  always_comb begin
    top_d = top_q;
    if (wr && sel == SEL_TOP_SET) top_d = top_d | bus_wdata;
    if (wr && sel == SEL_TOP_CLR) top_d = top_d & ~bus_wdata;
    if (evt_valid) top_d[evt_num] = evt_level;
    if (usb_upd) begin
      top_d[USB_TX_BIT] = usb_sum[0];
      top_d[USB_RX_BIT] = usb_sum[1];
    end
    if (dma_upd) top_d[DMA_SUM_BIT] = dma_sum[0];
  end

  logic any_pend;
  assign any_pend = |(top_q & ~tmask_q);

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    case (sel)
      SEL_TOP_SRC, SEL_TOP_SET, SEL_TOP_CLR: rd_mux = top_q;
      SEL_TOP_MASK:                          rd_mux = tmask_q;
      SEL_USB_SRC, SEL_USB_SET, SEL_USB_CLR: rd_mux = usb_pend_q;
      SEL_USB_MASK:                          rd_mux = usb_mask_q;
      SEL_DMA_SRC, SEL_DMA_SET, SEL_DMA_CLR: rd_mux = dma_pend_q;
      SEL_DMA_MASK:                          rd_mux = dma_mask_q;
      SEL_CFG:                               rd_mux = cfg_q;
      default:                               rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q         <= '0;
      tmask_q       <= '1;
      cfg_q         <= '0;
      irq           <= 1'b0;
      rsp_valid     <= 1'b0;
      rsp_data      <= '0;
      usb_clr_valid <= 1'b0;
      usb_clr_data  <= '0;
    end else begin
      top_q <= top_d;
      if (wr && sel == SEL_TOP_MASK) tmask_q <= bus_wdata;
      if (wr && sel == SEL_CFG)      cfg_q   <= bus_wdata;
      irq           <= hold_en & (cfg_q[POL_BIT] ? any_pend : ~any_pend);
      rsp_valid     <= rd;
      rsp_data      <= rd ? rd_mux : '0;
      usb_clr_valid <= wr && sel == SEL_USB_CLR;
      usb_clr_data  <= (wr && sel == SEL_USB_CLR) ? ~bus_wdata : '0;
    end
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bad_addr,
  input logic              rsp_valid,
  input logic              usb_clr_valid,
  input logic [DATA_W-1:0] usb_clr_data,
  input logic              hold_en,
  input logic              irq,
  input logic              pwr_on,
  input logic              usb_upd,
  input logic              dma_upd,
  input logic [DATA_W-1:0] top_q,
  input logic [DATA_W-1:0] usb_pend_q,
  input logic [DATA_W-1:0] usb_mask_q,
  input logic [DATA_W-1:0] dma_pend_q,
  input logic [DATA_W-1:0] dma_mask_q,
  input logic [DATA_W-1:0] cfg_q
);
  localparam int unsigned HW = DATA_W / 2;

  assert_tx_summary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    usb_upd |=> top_q[USB_TX_BIT] == |(usb_pend_q[HW-1:0] & ~usb_mask_q[HW-1:0]));

  assert_rx_summary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    usb_upd |=> top_q[USB_RX_BIT] == |(usb_pend_q[DATA_W-1:HW] & ~usb_mask_q[DATA_W-1:HW]));

  assert_dma_summary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_upd |=> top_q[DMA_SUM_BIT] == |(dma_pend_q & ~dma_mask_q));

  assert_gate_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_en |=> !irq);

  assert_power_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_on) |=> !hold_en);

  assert_clr_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == ADDR_W'(OFS_USB_CLR))
      |=> (usb_clr_valid && usb_clr_data == ~$past(bus_wdata)));

  assert_clr_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write && bus_addr == ADDR_W'(OFS_USB_CLR)) |=> !usb_clr_valid);

  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bad_addr) |=> $stable(cfg_q));

  assert_rsp_timing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rsp_valid);

  assert_rsp_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !rsp_valid);
endmodule

bind irq_aggregator irq_aggregator_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bad_addr(bad_addr),
  .rsp_valid(rsp_valid), .usb_clr_valid(usb_clr_valid), .usb_clr_data(usb_clr_data),
  .hold_en(hold_en), .irq(irq), .pwr_on(pwr_on), .usb_upd(usb_upd), .dma_upd(dma_upd),
  .top_q(top_q), .usb_pend_q(usb_pend_q), .usb_mask_q(usb_mask_q),
  .dma_pend_q(dma_pend_q), .dma_mask_q(dma_mask_q), .cfg_q(cfg_q)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  localparam int HOLD = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        evt_valid = 1'b0, evt_level = 1'b0, pwr_on = 1'b0;
  logic [4:0]  evt_num = '0;
  logic        bus_ready, rsp_valid, irq, usb_clr_valid;
  logic [31:0] rsp_data, usb_clr_data;

  always #2 clk = ~clk;

  irq_aggregator #(.HOLD_CYCLES(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .evt_valid(evt_valid),
    .evt_num(evt_num), .evt_level(evt_level), .pwr_on(pwr_on), .irq(irq),
    .usb_clr_valid(usb_clr_valid), .usb_clr_data(usb_clr_data)
  );

  int checks = 0, fails = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_top, m_tmask, m_usb, m_umask, m_dma, m_dmask, m_cfg;
  logic        m_en, m_pwr, m_irq, m_rv, m_cv;
  logic [31:0] m_rd, m_cd;
  int          m_cnt;

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00, 8'h04, 8'h08: return m_top;
      8'h0C:               return m_tmask;
      8'h10, 8'h14, 8'h18: return m_usb;
      8'h1C:               return m_umask;
      8'h20, 8'h24, 8'h28: return m_dma;
      8'h2C:               return m_dmask;
      8'h30:               return m_cfg;
      default:             return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_top = 0; m_tmask = '1; m_usb = 0; m_umask = 0; m_dma = 0; m_dmask = 0;
      m_cfg = 0; m_en = 0; m_pwr = 0; m_irq = 0; m_rv = 0; m_cv = 0;
      m_rd = 0; m_cd = 0; m_cnt = 0;
    end else begin
      bit any, utouch, dtouch;
      any = (m_top & ~m_tmask) != 0;
      m_irq = m_en && (m_cfg[17] ? any : !any);
      m_rv = bus_valid && !bus_write;
      m_rd = m_rv ? model_read(bus_addr) : 0;
      m_cv = bus_valid && bus_write && bus_addr == 8'h18;
      m_cd = m_cv ? ~bus_wdata : 0;
      utouch = 0; dtouch = 0;
      if (bus_valid && bus_write) begin
        case (bus_addr)
          8'h04: m_top |= bus_wdata;
          8'h08: m_top &= ~bus_wdata;
          8'h0C: m_tmask = bus_wdata;
          8'h14: begin m_usb |= bus_wdata; utouch = 1; end
          8'h18: begin m_usb &= ~bus_wdata; utouch = 1; end
          8'h1C: begin m_umask = bus_wdata; utouch = 1; end
          8'h24: begin m_dma |= bus_wdata; dtouch = 1; end
          8'h28: begin m_dma &= ~bus_wdata; dtouch = 1; end
          8'h2C: begin m_dmask = bus_wdata; dtouch = 1; end
          8'h30: m_cfg = bus_wdata;
          default: ;
        endcase
      end
      if (evt_valid) m_top[evt_num] = evt_level;
      if (utouch) begin
        m_top[9] = (m_usb[15:0] & ~m_umask[15:0]) != 0;
        m_top[8] = (m_usb[31:16] & ~m_umask[31:16]) != 0;
      end
      if (dtouch) m_top[24] = (m_dma & ~m_dmask) != 0;
      if (pwr_on && !m_pwr) begin
        m_en = 0; m_cnt = HOLD;
      end else if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) m_en = pwr_on;
      end
      m_pwr = pwr_on;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 irq vs model", {31'b0, irq}, {31'b0, m_irq});
      chk("R11 rsp_valid vs model", {31'b0, rsp_valid}, {31'b0, m_rv});
      if (m_rv) chk("R1 rsp_data vs model", rsp_data, m_rd);
      chk("R9 strobe vs model", {31'b0, usb_clr_valid}, {31'b0, m_cv});
      if (m_cv) chk("R9 strobe data vs model", usb_clr_data, m_cd);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    d = rsp_data;
    #1 bus_valid = 0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic evt(input logic [4:0] n, input logic lvl);
    @(negedge clk); #1;
    evt_valid = 1; evt_num = n; evt_level = lvl;
    @(negedge clk); #1;
    evt_valid = 0;
  endtask

  initial begin : watchdog
    cyc(20000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    cyc(3);
    #1 rst_n = 1;
    cyc(1);
    chk("R2 irq after reset", {31'b0, irq}, 32'h0);
    chk("R11 bus_ready", {31'b0, bus_ready}, 32'h1);
    rd(8'h0C, v); chk("R2 top mask reset", v, 32'hFFFF_FFFF);
    rd(8'h1C, v); chk("R2 usb mask reset", v, 32'h0);
    rd(8'h00, v); chk("R2 top pending reset", v, 32'h0);

    // power up, polarity 0 with all masked -> active after hold-off
    @(negedge clk); #1 pwr_on = 1;
    cyc(3);
    chk("R6 held during hold-off", {31'b0, irq}, 32'h0);
    cyc(HOLD + 2);
    chk("R5 low-polarity idle active", {31'b0, irq}, 32'h1);

    // high polarity, unmask
    wr(8'h30, 32'h0002_0000);
    cyc(1);
    chk("R5 high polarity nothing pending", {31'b0, irq}, 32'h0);
    wr(8'h0C, 32'h0);
    wr(8'h04, 32'h5);
    cyc(1);
    chk("R5 high polarity pending", {31'b0, irq}, 32'h1);
    rd(8'h04, v); chk("R1 read via set", v, 32'h5);
    wr(8'h08, 32'h1);
    rd(8'h08, v); chk("R1 read via clear", v, 32'h4);
    wr(8'h08, 32'h4);

    // USB group
    wr(8'h14, 32'h0001_0001);
    rd(8'h00, v); chk("R3 both summaries", v, 32'h0000_0300);
    wr(8'h1C, 32'h0000_FFFF);
    rd(8'h00, v); chk("R3 low half masked", v, 32'h0000_0100);
    wr(8'h18, 32'h0001_0000);
    rd(8'h10, v); chk("R9 usb after clear", v, 32'h0000_0001);
    rd(8'h00, v); chk("R3 summaries cleared", v, 32'h0);

    // DMA group
    wr(8'h24, 32'h4);
    rd(8'h00, v); chk("R4 dma summary", v, 32'h0100_0000);
    wr(8'h2C, 32'h4);
    rd(8'h00, v); chk("R4 dma masked", v, 32'h0);

    // events
    evt(5'd3, 1'b1);
    rd(8'h00, v); chk("R8 event sets", v, 32'h8);
    evt(5'd3, 1'b0);
    rd(8'h00, v); chk("R8 event clears", v, 32'h0);

    // unmapped
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, v); chk("R10 unmapped read", v, 32'h0);
    rd(8'h30, v); chk("R10 cfg untouched", v, 32'h0002_0000);

    // power cycling: off keeps enable; on restarts
    wr(8'h04, 32'h2);
    cyc(1);
    @(negedge clk); #1 pwr_on = 0;
    cyc(3);
    chk("R7 off keeps enable", {31'b0, irq}, 32'h1);
    @(negedge clk); #1 pwr_on = 1;
    cyc(3);
    chk("R7 on restarts hold-off", {31'b0, irq}, 32'h0);
    @(negedge clk); #1 pwr_on = 0;
    cyc(HOLD + 4);
    chk("R6 off at expiry stays gated", {31'b0, irq}, 32'h0);
    @(negedge clk); #1 pwr_on = 1;
    cyc(HOLD + 4);
    chk("R6 on at expiry enables", {31'b0, irq}, 32'h1);

    cyc(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule